// File: doc/BRIEF.md
# Pipelined Zero-Turnaround Synchronous SRAM

This block models a synchronous, pipelined memory with a 36-bit word. It takes a new read or write command on every enabled clock edge. Reads and writes can alternate freely with no idle cycles between them. A command carries an address, a write flag and four lane selects. Write data follows its command by two enabled clocks. Read data leaves through an output register, also two enabled clocks after the command. The shared data bus is split into an input bus, an output bus and a flag that says when the memory would drive the bus.

Because write data arrives late, a read can reach the array in the same edge that commits the write issued just before it. The block forwards the incoming write lanes into that read and merges them with the stored lanes, so every read returns the result of all earlier writes. An advance/load input starts a command at a given address, or continues a four-beat burst on the two low address bits. The burst order is linear or interleaved. Three chip enables of mixed polarity qualify each load. A clock enable freezes the whole pipeline.

Top module: `pipe_sram`

## Requirements
- R1: While `rst_n` is low at a clock edge, the block empties its pipeline. After that edge, `rdValid` is 0 and `rdData` is 0.
- R2: A read command sampled at an enabled edge gives its word on `rdData` after the second enabled edge that follows. `rdValid` is 1 for that cycle only, unless the next command is also a read.
- R3: A write command sampled at an enabled edge takes `wrData` at the second enabled edge after it. Lane i is bits [9i+8:9i], and it is stored only when the command's `byteSel[i]` is 1.
- R4: A read always returns the effect of every earlier write, including a write issued on the cycle just before it. That includes lanes merged from a partial write whose data has not yet reached the array.
- R5: A load (`advLoad`=0) starts a command only when `ceA_n`=0, `ceB`=1 and `ceC_n`=0. Otherwise the cycle is a deselect: nothing is written, and `rdValid` is 0 two enabled clocks later.
- R6: When `clkEn` is 0 at an edge, the block captures no input and commits no write. `rdData` and `rdValid` hold their values.
- R7: `rdValid` is 0 during the cycle in which write data for a write command is taken.
- R8: An advance (`advLoad`=1) after a load with `burstIlv`=0 accesses beat k of the burst. Beat k uses low address bits equal to (start + k) mod 4, and the upper bits are unchanged.
- R9: With `burstIlv`=1 sampled at the load, beat k uses low address bits equal to start XOR k.
- R10: An advance repeats the read/write type of the burst it continues. The chip enables have no effect on an advance. An advance after a deselect is itself a deselect. A write advance uses the `byteSel` value present on its own cycle.
- R11: Reads and writes may alternate on consecutive enabled cycles with no wait states, and each returns or stores the correct data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rst_n | input | 1 | Synchronous active-low pipeline reset |
| clkEn | input | 1 | Clock qualifier; 0 freezes the block |
| addr | input | ADDR_W | Word address for a load |
| wrEn | input | 1 | 1 = write command, 0 = read (on a load) |
| byteSel | input | 4 | Lane write selects; bit i covers bits [9i+8:9i] |
| ceA_n | input | 1 | Chip enable, active low |
| ceB | input | 1 | Chip enable, active high |
| ceC_n | input | 1 | Chip enable, active low |
| advLoad | input | 1 | 0 = load new command, 1 = advance burst |
| burstIlv | input | 1 | Burst order at load: 0 linear, 1 interleaved |
| wrData | input | 36 | Write data, taken two enabled clocks after its command |
| rdData | output | 36 | Registered read data |
| rdValid | output | 1 | 1 when the memory would drive the shared bus |

## Verification
The bench targets a read issued immediately after a partial write to the same address. A design without forwarding would return stale lanes there, and one that ignored the lane mask would overwrite lanes that were never written. It also places stalls inside bursts and between a write command and its data phase. A design that let any register advance while `clkEn` is low would take the wrong `wrData` or change its output. Linear and interleaved bursts from odd starting offsets expose any wrap that carries into the upper address bits. Loads with each chip enable wrong in turn, and advances after a deselect, catch a polarity error or a burst that keeps running after it should stop.

// File: rtl/pipe_sram_pkg.sv
package pipe_sram_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  // strobes from the control half to the datapath half
  typedef struct packed {
    logic             wrEn;     // write in stage two commits on this edge
    logic [LANES-1:0] wrMask;   // lanes of that write
    logic             rdEn;     // read in stage one samples the array
    logic [LANES-1:0] fwdMask;  // lanes to take from the incoming write data
    logic             outDrive; // stage two holds a read: load output
  } strobe_t;
endpackage

// File: rtl/pipe_sram_ctrl.sv
module pipe_sram_ctrl
  import pipe_sram_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [LANES-1:0]  byteSel,
  input  logic              ceA_n,
  input  logic              ceB,
  input  logic              ceC_n,
  input  logic              advLoad,
  input  logic              burstIlv,
  output strobe_t           strb,
  output logic [ADDR_W-1:0] wrAddr,
  output logic [ADDR_W-1:0] rdAddr
);
  typedef struct packed {
    logic              valid;
    logic              isWr;
    logic [ADDR_W-1:0] addr;
    logic [LANES-1:0]  mask;
  } stage_t;

  stage_t stageOne, stageTwo, newCmd;

  // burst state captured at each load
  logic              burstLive;
  logic              burstWr;
  logic              burstOrderIlv;
  logic [ADDR_W-1:0] burstBase;
  logic [1:0]        burstBeat;

  logic       chipOn;
  logic [1:0] nextBeat;
  logic [1:0] advLow;

  assign chipOn   = !ceA_n && ceB && !ceC_n;
  assign nextBeat = burstBeat + 2'd1;
  assign advLow   = burstOrderIlv ? (burstBase[1:0] ^ nextBeat)
                                  : (burstBase[1:0] + nextBeat);

  always_comb begin
    newCmd = '0;
    if (!advLoad) begin
      newCmd.valid = chipOn;
      newCmd.isWr  = wrEn;
      newCmd.addr  = addr;
      newCmd.mask  = byteSel;
    end else begin
      newCmd.valid = burstLive;
      newCmd.isWr  = burstWr;
      newCmd.addr  = {burstBase[ADDR_W-1:2], advLow};
      newCmd.mask  = byteSel;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stageOne      <= '0;
      stageTwo      <= '0;
      burstLive     <= 1'b0;
      burstWr       <= 1'b0;
      burstOrderIlv <= 1'b0;
      burstBase     <= '0;
      burstBeat     <= 2'd0;
    end else if (clkEn) begin
      stageOne <= newCmd;
      stageTwo <= stageOne;
      if (!advLoad) begin
        burstLive     <= chipOn;
        burstWr       <= wrEn;
        burstOrderIlv <= burstIlv;
        burstBase     <= addr;
        burstBeat     <= 2'd0;
      end else begin
        burstBeat <= nextBeat;
      end
    end
  end

  logic sameWord;
  assign sameWord = (stageTwo.addr == stageOne.addr);

  always_comb begin
    strb          = '0;
    strb.wrEn     = stageTwo.valid && stageTwo.isWr;
    strb.wrMask   = stageTwo.mask;
    strb.rdEn     = stageOne.valid && !stageOne.isWr;
    strb.fwdMask  = (strb.wrEn && strb.rdEn && sameWord) ? stageTwo.mask : '0;
    strb.outDrive = stageTwo.valid && !stageTwo.isWr;
  end

  assign wrAddr = stageTwo.addr;
  assign rdAddr = stageOne.addr;
endmodule

// File: rtl/pipe_sram_dp.sv
module pipe_sram_dp
  import pipe_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkEn,
  input  strobe_t           strb,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [ADDR_W-1:0] rdAddr,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic              rdValid
);
  logic [LANES-1:0][LANE_W-1:0] mem [DEPTH];
  logic [LANES-1:0][LANE_W-1:0] inLanes;
  logic [LANES-1:0][LANE_W-1:0] merged;
  logic [WORD_W-1:0]            rdHold;

  assign inLanes = wrData;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (clkEn && strb.wrEn && strb.wrMask[g]) begin
        mem[wrAddr][g] <= inLanes[g];
      end
    end
    assign merged[g] = strb.fwdMask[g] ? inLanes[g] : mem[rdAddr][g];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rdHold  <= '0;
      rdData  <= '0;
      rdValid <= 1'b0;
    end else if (clkEn) begin
      if (strb.rdEn) rdHold <= merged;
      if (strb.outDrive) rdData <= rdHold;
      rdValid <= strb.outDrive;
    end
  end
endmodule

// File: rtl/pipe_sram.sv
module pipe_sram
  import pipe_sram_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clkEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wrEn,
  input  logic [3:0]        byteSel,
  input  logic              ceA_n,
  input  logic              ceB,
  input  logic              ceC_n,
  input  logic              advLoad,
  input  logic              burstIlv,
  input  logic [35:0]       wrData,
  output logic [35:0]       rdData,
  output logic              rdValid
);
  strobe_t           strb;
  logic [ADDR_W-1:0] wrAddr;
  logic [ADDR_W-1:0] rdAddr;

  pipe_sram_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .clkEn(clkEn), .addr(addr), .wrEn(wrEn),
    .byteSel(byteSel), .ceA_n(ceA_n), .ceB(ceB), .ceC_n(ceC_n),
    .advLoad(advLoad), .burstIlv(burstIlv), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr)
  );

  pipe_sram_dp #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) dp_i (
    .clk(clk), .rst_n(rst_n), .clkEn(clkEn), .strb(strb),
    .wrAddr(wrAddr), .rdAddr(rdAddr), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/pipe_sram_chk.sv
module pipe_sram_chk
  import pipe_sram_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        clkEn,
  input logic        ceA_n,
  input logic        ceB,
  input logic        ceC_n,
  input logic        advLoad,
  input strobe_t     strb,
  input logic [35:0] rdData,
  input logic        rdValid
);
  // R1
  reset_idle_chk: assert property (@(posedge clk)
    !rst_n |=> (!rdValid && rdData == '0));

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clkEn |=> ($stable(rdValid) && $stable(rdData)));

  // R2
  read_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clkEn && strb.rdEn) |=> strb.outDrive);

  // R2
  read_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clkEn && strb.outDrive) |=> rdValid);

  // R7
  write_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clkEn && strb.wrEn) |=> !rdValid);

  // R5
  deselect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clkEn && !advLoad && !(!ceA_n && ceB && !ceC_n)) |=> !strb.rdEn);

  // R4
  forward_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.fwdMask != '0) |-> (strb.wrEn && strb.rdEn));
endmodule

bind pipe_sram pipe_sram_chk chk_i (
  .clk(clk), .rst_n(rst_n), .clkEn(clkEn), .ceA_n(ceA_n), .ceB(ceB),
  .ceC_n(ceC_n), .advLoad(advLoad), .strb(strb), .rdData(rdData),
  .rdValid(rdValid)
);

// File: tb/pipe_sram_tb_top.sv
module pipe_sram_tb_top;
  localparam int PERIOD = 10;
  localparam int DEPTH  = 256;
  localparam int AW     = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clkEn = 1'b1;
  logic [AW-1:0] addr = '0;
  logic          wrEn = 1'b0;
  logic [3:0]    byteSel = 4'hF;
  logic          ceA_n = 1'b1;
  logic          ceB = 1'b0;
  logic          ceC_n = 1'b1;
  logic          advLoad = 1'b0;
  logic          burstIlv = 1'b0;
  logic [35:0]   wrData = '0;
  logic [35:0]   rdData;
  logic          rdValid;

  always #(PERIOD/2) clk = ~clk;

  pipe_sram #(.DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst_n(rst_n), .clkEn(clkEn), .addr(addr), .wrEn(wrEn),
    .byteSel(byteSel), .ceA_n(ceA_n), .ceB(ceB), .ceC_n(ceC_n),
    .advLoad(advLoad), .burstIlv(burstIlv), .wrData(wrData),
    .rdData(rdData), .rdValid(rdValid)
  );

  typedef struct {
    logic          v;
    logic          w;
    logic [AW-1:0] a;
    logic [3:0]    m;
    logic [35:0]   d;
  } rec_t;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [35:0] refMem [DEPTH];
  rec_t agedOne, agedTwo;
  logic        expV;
  logic [35:0] expD;
  logic          mLive, mWr, mIlv;
  logic [AW-1:0] mBase;
  logic [1:0]    mBeat;

  function automatic logic [35:0] mergeLanes(logic [35:0] old, logic [35:0] nw,
                                             logic [3:0] m);
    logic [35:0] r = old;
    for (int i = 0; i < 4; i++) if (m[i]) r[i*9 +: 9] = nw[i*9 +: 9];
    return r;
  endfunction

  function automatic logic [AW-1:0] beatAddr(logic [AW-1:0] base, logic [1:0] k,
                                             logic ilv);
    logic [1:0] low = ilv ? (base[1:0] ^ k) : (base[1:0] + k);
    return {base[AW-1:2], low};
  endfunction

  function automatic logic [35:0] rnd36();
    return {$urandom(), $urandom()};
  endfunction

  task automatic modelReset();
    agedOne = '{default: '0};
    agedTwo = '{default: '0};
    expV = 1'b0; expD = '0;
    mLive = 0; mWr = 0; mIlv = 0; mBase = '0; mBeat = 2'd0;
  endtask

  task automatic check(string tag);
    checks++;
    if (rdValid !== expV || rdData !== expD) begin
      fails++;
      $display("FAIL %s: rdValid=%0b rdData=%h expected rdValid=%0b rdData=%h",
               tag, rdValid, rdData, expV, expD);
    end
  endtask

  // one cycle; called at a falling edge, returns at the next falling edge
  task automatic cyc(bit en, bit adv, bit cA, bit cB, bit cC, bit we,
                     logic [AW-1:0] ad, logic [3:0] sel, bit ilv, string tag);
    rec_t nr;
    string t = tag;
    clkEn = en; advLoad = adv; ceA_n = cA; ceB = cB; ceC_n = cC;
    wrEn = we; addr = ad; byteSel = sel; burstIlv = ilv;
    wrData = (en && agedTwo.v && agedTwo.w) ? agedTwo.d : rnd36();
    if (en) begin
      nr.m = sel; nr.d = rnd36();
      if (!adv) begin
        nr.v = !cA && cB && !cC; nr.w = we; nr.a = ad;
        mLive = nr.v; mWr = we; mBase = ad; mBeat = 2'd0; mIlv = ilv;
      end else begin
        mBeat = mBeat + 2'd1;
        nr.v = mLive; nr.w = mWr; nr.a = beatAddr(mBase, mBeat, mIlv);
      end
      if (agedTwo.v && agedTwo.w) begin
        refMem[agedTwo.a] = mergeLanes(refMem[agedTwo.a], agedTwo.d, agedTwo.m);
        t = "R7";
      end
      expV = agedTwo.v && !agedTwo.w;
      if (expV) expD = refMem[agedTwo.a];
      agedTwo = agedOne;
      agedOne = nr;
    end
    @(negedge clk);
    check(t);
  endtask

  task automatic ld(bit we, logic [AW-1:0] ad, logic [3:0] sel, bit ilv, string tag);
    cyc(1, 0, 0, 1, 0, we, ad, sel, ilv, tag);
  endtask

  task automatic advc(logic [3:0] sel, string tag);
    cyc(1, 1, 1, 0, 1, 0, '0, sel, 0, tag);
  endtask

  task automatic idle(string tag);
    cyc(1, 0, 1, 0, 1, 0, '0, 4'h0, 0, tag);
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    check("R1");  // reset state: not driving, zero data

    // R3: fill every word with full-lane writes
    for (int i = 0; i < DEPTH; i++) ld(1, AW'(i), 4'hF, 0, "R3");
    idle("R3"); idle("R3");

    // R4: partial write then immediate read of the same word
    ld(1, 8'd5, 4'b0101, 0, "R3");
    ld(0, 8'd5, 4'h0, 0, "R4");
    ld(0, 8'd5, 4'h0, 0, "R4");
    ld(1, 8'd6, 4'b1000, 0, "R3");
    ld(0, 8'd6, 4'hF, 0, "R4");
    idle("R4"); idle("R4");

    // R11: alternating read and write, no gaps
    for (int i = 0; i < 8; i++) ld(i[0], AW'(16 + (i >> 1)), 4'hF, 0, "R11");
    for (int i = 0; i < 4; i++) ld(0, AW'(16 + i), 4'h0, 0, "R11");
    idle("R11"); idle("R11");

    // R5: each chip enable wrong in turn on a write to word 9
    cyc(1, 0, 1, 1, 0, 1, 8'd9, 4'hF, 0, "R5");
    cyc(1, 0, 0, 0, 0, 1, 8'd9, 4'hF, 0, "R5");
    cyc(1, 0, 0, 1, 1, 1, 8'd9, 4'hF, 0, "R5");
    cyc(1, 0, 1, 1, 0, 0, 8'd9, 4'hF, 0, "R5");
    ld(0, 8'd9, 4'h0, 0, "R5");
    idle("R5"); idle("R5");

    // R6: stalls between write command and its data phase, and mid read
    ld(1, 8'd20, 4'hF, 0, "R6");
    cyc(0, 0, 0, 1, 0, 1, 8'd21, 4'hF, 0, "R6");
    cyc(0, 0, 0, 1, 0, 1, 8'd21, 4'hF, 0, "R6");
    ld(0, 8'd20, 4'h0, 0, "R6");
    cyc(0, 1, 0, 1, 0, 0, 8'd22, 4'h0, 0, "R6");
    idle("R6");
    cyc(0, 0, 0, 1, 0, 1, 8'd23, 4'hF, 0, "R6");
    idle("R6"); idle("R6");

    // R8: linear burst read from offset 2
    ld(0, 8'h12, 4'h0, 0, "R8");
    repeat (3) advc(4'h0, "R8");
    // R9: interleaved burst read from offset 3
    ld(0, 8'h13, 4'h0, 1, "R9");
    repeat (3) advc(4'h0, "R9");
    idle("R9"); idle("R9");

    // R10: linear write burst with varying lane selects, then read back
    ld(1, 8'h29, 4'hF, 0, "R10");
    advc(4'b0011, "R10");
    advc(4'b1100, "R10");
    advc(4'b0001, "R10");
    ld(0, 8'h28, 4'h0, 0, "R10");
    repeat (3) advc(4'h0, "R10");
    // R10: advance after a deselect stays deselected
    idle("R10");
    advc(4'hF, "R10"); advc(4'hF, "R10");
    idle("R10"); idle("R10");

    // random back-to-back traffic with stalls and deselects
    for (int i = 0; i < 4000; i++) begin
      bit en  = ($urandom_range(9) != 0);
      bit adv = ($urandom_range(2) == 0);
      bit on  = ($urandom_range(6) != 0);
      bit cA  = on ? 1'b0 : 1'($urandom_range(1));
      bit cB  = on ? 1'b1 : 1'b0;
      cyc(en, adv, cA, cB, 1'b0, 1'($urandom_range(1)),
          AW'($urandom_range(31)), 4'($urandom_range(15)),
          1'($urandom_range(1)), "R2");
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial void'($urandom(32'h5A17));
endmodule